// File: doc/BRIEF.md
# TDM Serial Word Receiver with Status Flags

This block takes a serial data stream cut into time slots and turns it into parallel words. A bit-clock enable marks when a bit is valid. A frame-sync input says which slot opens a frame. The receiver shifts each bit into a 24-bit shift register, in either bit order. Once the selected number of bits (8, 12, 16 or 24) has arrived, it moves the word into a holding register, aligned to the top. After the first frame sync, slots follow one another with no gap until the receiver is disabled.

Next to the data the block keeps a small status byte. It holds a data-full flag, an overrun flag, a first-slot tag for the word now held, and two auxiliary input flags. The auxiliary flags are sampled from side pins on the first bit after frame sync. A CPU reads the holding register and the zero-extended status through strobed reads. A read of the held word empties it. The overrun flag needs a status read and then a data read before it clears. A receive interrupt request comes with a vector select that points to an exception handler while overrun is set.

Top module: `tdm_rx_status`

## Requirements
- R1: `wordLenSel` sets the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 24. A word moves to the holding register on the bit tick that completes that many bits, and not before.
- R2: With `lsbFirst` = 0 the first bit received is the most significant bit of the word. With `lsbFirst` = 1 it is the least significant bit.
- R3: The held word occupies bits 23 down to 24-N of `rxData`. The bits below that read as zero.
- R4: Status bit 7 (full) sets when a word moves to the holding register. It clears on a `readData` pulse.
- R5: If a word completes while full is set, status bit 5 (overrun) sets, the new word is dropped, and `rxData` keeps its old value.
- R6: Overrun clears only after a `readStatus` pulse that sees it set, followed later by a `readData` pulse. A `readData` pulse alone does not clear it. Taking `rxEnable` low does not clear it.
- R7: `rxIrq` is high while `intEnable` and full are both set. `irqVecExc` is 1 while overrun is set and 0 otherwise.
- R8: Status bit 3 (first-slot) is 1 for a held word whose first bit saw `frameSync` high, and 0 for later slots of the same frame. This is the word-wide sync mode, `bitWideSync` = 0.
- R9: With `bitWideSync` = 1, a slot is the first of its frame when `frameSync` was high on the bit tick just before the slot's first bit. That earlier tick does not itself start a word.
- R10: Status bits 0 and 1 show `auxPin0` and `auxPin1` as sampled on the first bit after frame sync. They take the new value only when a word moves into the holding register, and they keep it for later slots of the same frame.
- R11: Status bit 0 reads 0 unless `aux0IsInput` and `syncMode` are both 1. Bit 1 reads 0 unless `aux1IsInput` and `syncMode` are both 1.
- R12: `statusBus[23:8]` and status bits 6, 4 and 2 always read as zero.
- R13: A `swReset` pulse clears every status flag within one cycle. It also drops any partly received word, so the next word must start again with frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swReset | input | 1 | Synchronous clear of flags and framing |
| rxEnable | input | 1 | Receiver enable; low drops framing and any partial word |
| bitTick | input | 1 | One-cycle pulse per serial bit |
| serData | input | 1 | Serial data, valid on `bitTick` |
| frameSync | input | 1 | Frame sync, sampled on `bitTick` |
| auxPin0 | input | 1 | Auxiliary flag pin 0 |
| auxPin1 | input | 1 | Auxiliary flag pin 1 |
| wordLenSel | input | 2 | Word length code (8/12/16/24) |
| lsbFirst | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| bitWideSync | input | 1 | 1: sync one bit before the slot; 0: sync on the slot's first bit |
| aux0IsInput | input | 1 | Auxiliary pin 0 is configured as an input |
| aux1IsInput | input | 1 | Auxiliary pin 1 is configured as an input |
| syncMode | input | 1 | Synchronous mode selected |
| intEnable | input | 1 | Receive interrupt enable |
| readData | input | 1 | CPU read strobe for the held word |
| readStatus | input | 1 | CPU read strobe for the status |
| rxData | output | 24 | Held word, aligned to the MSB |
| statusBus | output | 24 | Status byte, zero-extended |
| rxIrq | output | 1 | Receive interrupt request |
| irqVecExc | output | 1 | Vector select: 1 exception, 0 normal |

## Verification
The assertions check the flag rules on every cycle. A completing word sets full when the holding register is empty and sets overrun when it is not. A dropped word leaves the held data untouched. Overrun stays set until its clear sequence or a software reset. The bit counter never reaches the selected word length. Bit order, alignment for each length, the choice between the two sync modes, the aux pin sampling and its gating, and the data-read-only case that must not clear overrun all need whole serial frames, so only the bench scenarios can show them.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int RX_W  = 24;
  localparam int CNT_W = $clog2(RX_W + 1);

  typedef struct packed {
    logic shift;      // a bit is taken on this cycle
    logic start;      // this bit opens a new word
    logic capAux;     // sample aux pins (first bit after sync)
    logic xfer;       // this bit completes the word
    logic firstSlot;  // completed word belongs to the sync slot
  } rxStrb_t;

  function automatic logic [CNT_W-1:0] wordBits(input logic [1:0] sel);
    case (sel)
      2'd0:    wordBits = CNT_W'(8);
      2'd1:    wordBits = CNT_W'(12);
      2'd2:    wordBits = CNT_W'(16);
      default: wordBits = CNT_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
  import tdm_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       rxEnable,
  input  logic       bitTick,
  input  logic       frameSync,
  input  logic       bitWideSync,
  input  logic [1:0] wordLenSel,
  output rxStrb_t    strb
);
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lenBits;
  logic             inFrame;
  logic             firstPend;
  logic             syncPrev;
  logic             tickUse;
  logic             slotSync;
  logic             startNow;
  logic             contNow;
  logic             lastNow;

  assign lenBits  = wordBits(wordLenSel);
  assign tickUse  = bitTick & rxEnable;
  assign slotSync = bitWideSync ? syncPrev : frameSync;
  assign startNow = tickUse && (bitCnt == '0) && (inFrame || slotSync);
  assign contNow  = tickUse && (bitCnt != '0);
  assign lastNow  = (startNow || contNow) && (bitCnt == lenBits - CNT_W'(1));

  always_comb begin
    strb.shift     = startNow | contNow;
    strb.start     = startNow;
    strb.capAux    = startNow & slotSync;
    strb.xfer      = lastNow;
    strb.firstSlot = firstPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      inFrame   <= 1'b0;
      firstPend <= 1'b0;
      syncPrev  <= 1'b0;
    end else begin
      if (swReset) syncPrev <= 1'b0;
      else if (bitTick) syncPrev <= frameSync;

      if (swReset || !rxEnable) begin
        bitCnt    <= '0;
        inFrame   <= 1'b0;
        firstPend <= 1'b0;
      end else if (startNow) begin
        bitCnt    <= CNT_W'(1);
        inFrame   <= 1'b1;
        firstPend <= slotSync;
      end else if (contNow) begin
        bitCnt    <= lastNow ? '0 : bitCnt + CNT_W'(1);
      end
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(wordLenSel) |-> (bitCnt < lenBits));

  // R13
  sw_clear_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (bitCnt == '0) && !inFrame);
endmodule

// File: rtl/tdm_rx_datapath.sv
module tdm_rx_datapath
  import tdm_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            swReset,
  input  rxStrb_t         strb,
  input  logic            serData,
  input  logic            lsbFirst,
  input  logic [1:0]      wordLenSel,
  input  logic [1:0]      auxPins,
  input  logic            holdFull,
  output logic [RX_W-1:0] holdData,
  output logic            holdFirst,
  output logic [1:0]      holdAux
);
  logic [RX_W-1:0]  shiftReg;
  logic [RX_W-1:0]  shiftBase;
  logic [RX_W-1:0]  shiftNext;
  logic [RX_W-1:0]  alignedWord;
  logic [RX_W-1:0]  topMask;
  logic [CNT_W-1:0] lenBits;
  logic [CNT_W-1:0] padBits;
  logic [1:0]       auxLatch;
  logic             loadHold;

  assign lenBits   = wordBits(wordLenSel);
  assign padBits   = CNT_W'(RX_W) - lenBits;
  assign topMask   = ~({RX_W{1'b1}} >> lenBits);
  assign shiftBase = strb.start ? '0 : shiftReg;
  assign shiftNext = lsbFirst ? {serData, shiftBase[RX_W-1:1]}
                              : {shiftBase[RX_W-2:0], serData};
  assign alignedWord = lsbFirst ? (shiftNext & topMask) : (shiftNext << padBits);
  assign loadHold  = strb.xfer & ~holdFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      holdData  <= '0;
      holdFirst <= 1'b0;
      holdAux   <= '0;
      auxLatch  <= '0;
    end else begin
      if (strb.shift) shiftReg <= shiftNext;
      if (strb.capAux) auxLatch <= auxPins;
      if (loadHold) holdData <= alignedWord;
      if (swReset) begin
        holdFirst <= 1'b0;
        holdAux   <= '0;
      end else if (loadHold) begin
        holdFirst <= strb.firstSlot;
        holdAux   <= auxLatch;
      end
    end
  end

  // R10
  aux_tag_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.xfer && !swReset) |=> $stable(holdAux));
endmodule

// File: rtl/tdm_rx_flags.sv
module tdm_rx_flags (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       xfer,
  input  logic       readData,
  input  logic       readStatus,
  input  logic       intEnable,
  input  logic       syncMode,
  input  logic [1:0] auxIsInput,
  input  logic       holdFirst,
  input  logic [1:0] holdAux,
  output logic       fullQ,
  output logic [7:0] statusByte,
  output logic       rxIrq,
  output logic       irqVecExc
);
  logic ovQ;
  logic ovArm;
  logic [1:0] auxVis;

  assign auxVis     = holdAux & auxIsInput & {2{syncMode}};
  assign statusByte = {fullQ, 1'b0, ovQ, 1'b0, holdFirst, 1'b0, auxVis};
  assign rxIrq      = intEnable & fullQ;
  assign irqVecExc  = ovQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullQ <= 1'b0;
      ovQ   <= 1'b0;
      ovArm <= 1'b0;
    end else if (swReset) begin
      fullQ <= 1'b0;
      ovQ   <= 1'b0;
      ovArm <= 1'b0;
    end else begin
      if (xfer && !fullQ) fullQ <= 1'b1;
      else if (readData) fullQ <= 1'b0;

      if (xfer && fullQ) ovQ <= 1'b1;
      else if (readData && ovArm) ovQ <= 1'b0;

      if (readData) ovArm <= 1'b0;
      else if (readStatus && ovQ) ovArm <= 1'b1;
    end
  end

  // R4
  full_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !fullQ && !swReset) |=> fullQ);

  // R5
  ov_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && fullQ && !swReset) |=> ovQ);

  // R6
  ov_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovQ && !swReset && !(readData && ovArm)) |=> ovQ);
endmodule

// File: rtl/tdm_rx_status.sv
module tdm_rx_status
  import tdm_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swReset,
  input  logic        rxEnable,
  input  logic        bitTick,
  input  logic        serData,
  input  logic        frameSync,
  input  logic        auxPin0,
  input  logic        auxPin1,
  input  logic [1:0]  wordLenSel,
  input  logic        lsbFirst,
  input  logic        bitWideSync,
  input  logic        aux0IsInput,
  input  logic        aux1IsInput,
  input  logic        syncMode,
  input  logic        intEnable,
  input  logic        readData,
  input  logic        readStatus,
  output logic [23:0] rxData,
  output logic [23:0] statusBus,
  output logic        rxIrq,
  output logic        irqVecExc
);
  rxStrb_t         strb;
  logic            holdFull;
  logic            holdFirst;
  logic [1:0]      holdAux;
  logic [7:0]      statusByte;
  logic [RX_W-1:0] holdData;

  tdm_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .rxEnable(rxEnable),
    .bitTick(bitTick), .frameSync(frameSync), .bitWideSync(bitWideSync),
    .wordLenSel(wordLenSel), .strb(strb)
  );

  tdm_rx_datapath u_dp (
    .clk(clk), .rstN(rstN), .swReset(swReset), .strb(strb),
    .serData(serData), .lsbFirst(lsbFirst), .wordLenSel(wordLenSel),
    .auxPins({auxPin1, auxPin0}), .holdFull(holdFull),
    .holdData(holdData), .holdFirst(holdFirst), .holdAux(holdAux)
  );

  tdm_rx_flags u_flags (
    .clk(clk), .rstN(rstN), .swReset(swReset), .xfer(strb.xfer),
    .readData(readData), .readStatus(readStatus), .intEnable(intEnable),
    .syncMode(syncMode), .auxIsInput({aux1IsInput, aux0IsInput}),
    .holdFirst(holdFirst), .holdAux(holdAux), .fullQ(holdFull),
    .statusByte(statusByte), .rxIrq(rxIrq), .irqVecExc(irqVecExc)
  );

  assign rxData    = holdData;
  assign statusBus = {16'h0000, statusByte};

  // R5
  drop_keeps_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xfer && holdFull) |=> $stable(rxData));
endmodule

// File: tb/tb_tdm_rx_status.sv
module tb_tdm_rx_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swReset = 0, rxEnable = 0, bitTick = 0, serData = 0, frameSync = 0;
  logic auxPin0 = 0, auxPin1 = 0;
  logic [1:0] wordLenSel = 2'd0;
  logic lsbFirst = 0, bitWideSync = 0, aux0IsInput = 0, aux1IsInput = 0;
  logic syncMode = 0, intEnable = 0, readData = 0, readStatus = 0;
  logic [23:0] rxData, statusBus;
  logic rxIrq, irqVecExc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tdm_rx_status dut (
    .clk(clk), .rstN(rstN), .swReset(swReset), .rxEnable(rxEnable),
    .bitTick(bitTick), .serData(serData), .frameSync(frameSync),
    .auxPin0(auxPin0), .auxPin1(auxPin1), .wordLenSel(wordLenSel),
    .lsbFirst(lsbFirst), .bitWideSync(bitWideSync), .aux0IsInput(aux0IsInput),
    .aux1IsInput(aux1IsInput), .syncMode(syncMode), .intEnable(intEnable),
    .readData(readData), .readStatus(readStatus), .rxData(rxData),
    .statusBus(statusBus), .rxIrq(rxIrq), .irqVecExc(irqVecExc)
  );

  // {wordLenSel, lsbFirst, word value in the low bits}
  localparam logic [26:0] VECS [6] = '{
    {2'd0, 1'b0, 24'h0000A5},
    {2'd0, 1'b1, 24'h00003C},
    {2'd1, 1'b0, 24'h000ABC},
    {2'd2, 1'b1, 24'h00BEEF},
    {2'd3, 1'b0, 24'h5A1234},
    {2'd3, 1'b1, 24'h81C3E7}
  };

  function automatic int bitsOf(input logic [1:0] sel);
    case (sel)
      2'd0: return 8;
      2'd1: return 12;
      2'd2: return 16;
      default: return 24;
    endcase
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic sendBit(input logic b, input logic s, input logic [1:0] aux);
    @(negedge clk);
    serData = b; frameSync = s; {auxPin1, auxPin0} = aux; bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
  endtask

  task automatic sendWord(input logic [23:0] val, input logic [1:0] sel, input logic lsb,
                          input logic s, input logic [1:0] auxA, input logic [1:0] auxB);
    int n;
    n = bitsOf(sel);
    wordLenSel = sel; lsbFirst = lsb;
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = lsb ? i : n - 1 - i;
      sendBit(val[idx], s && (i == 0), (i == 0) ? auxA : auxB);
    end
  endtask

  task automatic resetFrame();
    @(negedge clk); rxEnable = 1'b0;
    @(negedge clk); rxEnable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state, R12 zero fill
    check("R12 reset status", statusBus, 24'h0);
    check("R4 reset data", rxData, 24'h0);
    check("R7 reset irq", {22'h0, rxIrq, irqVecExc}, 24'h0);

    // table walk: R1 R2 R3 R4 R8
    foreach (VECS[k]) begin
      logic [1:0] sel;
      logic lsb;
      logic [23:0] val, exp;
      int n;
      {sel, lsb, val} = VECS[k];
      n = bitsOf(sel);
      exp = val << (24 - n);
      resetFrame();
      sendWord(val, sel, lsb, 1'b1, 2'b00, 2'b00);
      check("R1 R2 R3 word alignment", rxData, exp);
      check("R4 R8 full and first", statusBus, 24'h000088);
      pulse(readData);
      check("R4 full cleared by read", statusBus, 24'h000008);
    end

    // R7 normal vector
    intEnable = 1'b1;
    resetFrame();
    sendWord(24'h3C, 2'd0, 1'b0, 1'b1, 2'b00, 2'b00);
    check("R7 irq normal", {22'h0, rxIrq, irqVecExc}, 24'h2);
    pulse(readData);
    check("R7 irq drops after read", {22'h0, rxIrq, irqVecExc}, 24'h0);

    // R5 R6 overrun
    resetFrame();
    sendWord(24'h11, 2'd0, 1'b0, 1'b1, 2'b00, 2'b00);
    sendWord(24'h22, 2'd0, 1'b0, 1'b0, 2'b00, 2'b00);
    check("R5 old word kept", rxData, 24'h110000);
    check("R5 overrun set", statusBus, 24'h0000A8);
    check("R7 irq exception", {22'h0, rxIrq, irqVecExc}, 24'h3);
    @(negedge clk); rxEnable = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 disable keeps overrun", statusBus, 24'h0000A8);
    rxEnable = 1'b1;
    pulse(readData);
    check("R6 data read alone keeps overrun", statusBus, 24'h000028);
    pulse(readStatus);
    pulse(readData);
    check("R6 status then data read clears", statusBus, 24'h000008);
    intEnable = 1'b0;

    // R8 later slot in the frame
    resetFrame();
    sendWord(24'h55, 2'd0, 1'b0, 1'b1, 2'b00, 2'b00);
    pulse(readData);
    sendWord(24'h66, 2'd0, 1'b0, 1'b0, 2'b00, 2'b00);
    check("R8 second slot data", rxData, 24'h660000);
    check("R8 second slot not first", statusBus, 24'h000080);
    pulse(readData);

    // R10 R11 auxiliary flags
    syncMode = 1'b1; aux0IsInput = 1'b1; aux1IsInput = 1'b1;
    resetFrame();
    sendWord(24'h9A, 2'd0, 1'b0, 1'b1, 2'b01, 2'b10);
    check("R10 aux sampled on first bit", statusBus, 24'h000089);
    pulse(readData);
    sendWord(24'h77, 2'd0, 1'b0, 1'b0, 2'b10, 2'b10);
    check("R10 aux kept in later slot", statusBus, 24'h000081);
    aux0IsInput = 1'b0;
    @(negedge clk);
    check("R11 aux0 gated by direction", statusBus, 24'h000080);
    aux0IsInput = 1'b1; syncMode = 1'b0;
    @(negedge clk);
    check("R11 aux0 gated by mode", statusBus, 24'h000080);
    pulse(readData);

    // R9 bit-wide sync
    resetFrame();
    bitWideSync = 1'b1;
    sendBit(1'b1, 1'b1, 2'b00);
    check("R9 sync tick starts no word", statusBus, 24'h0);
    sendWord(24'hC3, 2'd0, 1'b0, 1'b0, 2'b00, 2'b00);
    check("R9 bit-wide data", rxData, 24'hC30000);
    check("R9 bit-wide first slot", statusBus, 24'h000088);
    bitWideSync = 1'b0;

    // R13 software reset, R1 partial word
    intEnable = 1'b1;
    pulse(swReset);
    check("R13 flags cleared", statusBus, 24'h0);
    check("R13 irq cleared", {23'h0, rxIrq}, 24'h0);
    resetFrame();
    for (int i = 0; i < 7; i++) sendBit(1'b0, i == 0, 2'b00);
    check("R1 no transfer before last bit", statusBus, 24'h0);
    pulse(swReset);
    sendWord(24'hE1, 2'd0, 1'b0, 1'b1, 2'b00, 2'b00);
    check("R13 partial word dropped", rxData, 24'hE10000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule